// File: doc/BRIEF.md
# Swappable Instruction-Pointer / Data-Pointer Register Pair

This block holds the two 16-bit address registers of a small 8-bit processor. It contains two identical preloadable counters and a one-bit role selector. At any moment one counter plays the instruction pointer (IP) and the other plays the data pointer (P). The IP advances when the sequencer asks for it. P is written and read one byte at a time over the 8-bit data path, with separate controls for its low and high bytes. Either counter can be put on the 16-bit address bus.

A jump copies no data. It toggles the role selector, so the counter that was P becomes the new IP, and the old IP stays readable as P. Software can keep that value as a return address. All state changes on the falling clock edge, so a sequencer that moves its controls on the rising edge gives the block half a cycle of settled inputs.

Top module: `ptr_pair`

## Requirements
- R1: After reset both counters hold 0x0000 and counter 0 is the IP. Incrementing then shows 0x0001 on the address bus when the IP is selected and 0x0000 when P is selected.
- R2: On a falling edge with `cnt_en` high, the IP counter advances by one. With `cnt_en` low it holds its value.
- R3: Incrementing never changes P.
- R4: `addr` carries P when `addr_from_ptr` is 1 and carries the IP when it is 0.
- R5: `wr_lo` loads `wr_data` into P bits [7:0] and `wr_hi` loads it into P bits [15:8]. Each load takes effect on the falling edge and leaves the other byte untouched.
- R6: `rd_valid` equals `rd_lo | rd_hi`. `rd_data` shows P[7:0] for `rd_lo` and P[15:8] for `rd_hi`, and is 0x00 when neither enable is high.
- R7: When `rd_lo` and `rd_hi` are both high, `rd_data` shows the low byte P[7:0].
- R8: A falling edge with `jump_en` high swaps the roles. The old P becomes the IP, and the old IP, holding the address of the next instruction, becomes P.
- R9: When an increment and a swap fall on the same edge, the increment applies to the old IP. The new P therefore equals the old IP plus one. A byte load on that edge writes the old P, which becomes the new IP.
- R10: A counter at 0xFFFF that is incremented wraps to 0x0000.
- R11: With `jump_en` low the roles do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Increment the current IP |
| jump_en | input | 1 | Swap the IP and P roles (taken jump) |
| addr_from_ptr | input | 1 | Address source: 1 = P, 0 = IP |
| wr_lo | input | 1 | Load low byte of P |
| wr_hi | input | 1 | Load high byte of P |
| rd_lo | input | 1 | Drive low byte of P onto `rd_data` |
| rd_hi | input | 1 | Drive high byte of P onto `rd_data` |
| wr_data | input | 8 | Byte to load into P |
| addr | output | 16 | Address bus |
| rd_data | output | 8 | Byte read from P |
| rd_valid | output | 1 | `rd_data` is being driven |

## Verification
The assertions assume every control input is a defined 0 or 1 and holds steady from shortly after the rising edge until past the falling edge that samples it. The checks on one-edge behaviour rely on this, in particular the toggle on a swap and the single-step increment. The bench changes inputs only one time unit after a rising edge and never drives X once reset is released. Its random stimulus may raise any mix of controls at once: load together with jump, increment together with jump, and both read enables together. This exercises the same-edge orderings inside that legal envelope.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_CTR = 2;
  // value of the role bit: index of the counter acting as IP
  typedef enum logic {
    IP_IS_C0 = 1'b0,
    IP_IS_C1 = 1'b1
  } role_e;
endpackage

// File: rtl/ptr_rst_sync.sv
module ptr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/ptr_ctr.sv
module ptr_ctr #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WIDTH = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] din,
  output logic [WIDTH-1:0]  q
);
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_d = q_r;
    if (inc) q_d = q_r + 1'b1;
    if (ld_lo) q_d[DATA_W-1:0] = din;
    if (ld_hi) q_d[WIDTH-1:DATA_W] = din;
  end

  assign q_en = inc | ld_lo | ld_hi;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;

  AST_INC_STEP: assert property (@(negedge clk) disable iff (!rst_n)
    inc && !ld_lo && !ld_hi |=> q == $past(q) + 1'b1); // R2
  AST_WRAP_ZERO: assert property (@(negedge clk) disable iff (!rst_n)
    inc && !ld_lo && !ld_hi && (q == {WIDTH{1'b1}}) |=> q == '0); // R10
  AST_HOLD_IDLE: assert property (@(negedge clk) disable iff (!rst_n)
    !inc && !ld_lo && !ld_hi |=> $stable(q)); // R3
endmodule

// File: rtl/ptr_role.sv
module ptr_role
  import ptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swap,
  output role_e ip_idx
);
  role_e role_r;
  role_e role_d;

  always_comb begin
    role_d = role_r;
    if (swap) role_d = (role_r == IP_IS_C0) ? IP_IS_C1 : IP_IS_C0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    role_r <= IP_IS_C0;
    else if (swap) role_r <= role_d;
  end

  assign ip_idx = role_r;

  AST_SWAP_TOGGLE: assert property (@(negedge clk) disable iff (!rst_n)
    swap |=> ip_idx != $past(ip_idx)); // R8
  AST_ROLE_KEEP: assert property (@(negedge clk) disable iff (!rst_n)
    !swap |=> $stable(ip_idx)); // R11
endmodule

// File: rtl/ptr_pair.sv
module ptr_pair
  import ptr_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              jump_en,
  input  logic              addr_from_ptr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              rst_int_n;
  role_e             ip_idx;
  logic [ADDR_W-1:0] ctr_q [NUM_CTR];
  logic [ADDR_W-1:0] ip_val;
  logic [ADDR_W-1:0] p_val;

  ptr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  ptr_role u_role (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .swap   (jump_en),
    .ip_idx (ip_idx)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic is_ip;
    assign is_ip = (ip_idx == role_e'(i));
    ptr_ctr #(.DATA_W(DATA_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_int_n),
      .inc   (cnt_en & is_ip),
      .ld_lo (wr_lo & ~is_ip),
      .ld_hi (wr_hi & ~is_ip),
      .din   (wr_data),
      .q     (ctr_q[i])
    );
  end

  always_comb begin
    if (ip_idx == IP_IS_C0) begin
      ip_val = ctr_q[0];
      p_val  = ctr_q[1];
    end else begin
      ip_val = ctr_q[1];
      p_val  = ctr_q[0];
    end
  end

  always_comb begin
    addr = addr_from_ptr ? p_val : ip_val;
  end

  always_comb begin
    rd_valid = rd_lo | rd_hi;
    if (rd_lo)      rd_data = p_val[DATA_W-1:0];
    else if (rd_hi) rd_data = p_val[ADDR_W-1:DATA_W];
    else            rd_data = '0;
  end

  AST_IDLE_BUS: assert property (@(negedge clk) disable iff (!rst_int_n)
    !rd_valid |-> rd_data == '0); // R6
  AST_RET_ADDR: assert property (@(negedge clk) disable iff (!rst_int_n)
    jump_en && cnt_en |=> p_val == $past(ip_val) + 1'b1); // R9
  AST_RET_PLAIN: assert property (@(negedge clk) disable iff (!rst_int_n)
    jump_en && !cnt_en |=> p_val == $past(ip_val)); // R8
endmodule

// File: tb/tb_ptr_pair.sv
`timescale 1ns/1ps
module tb_ptr_pair;
  localparam int CLK_P = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en, jump_en, addr_from_ptr, wr_lo, wr_hi, rd_lo, rd_hi;
  logic [7:0]  wr_data;
  logic [15:0] addr;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [15:0] m_c [2];
  logic        m_sel;

  always #(CLK_P/2) clk = ~clk;

  ptr_pair dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .jump_en(jump_en),
    .addr_from_ptr(addr_from_ptr), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_data(wr_data),
    .addr(addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [15:0] exp_addr(logic afp);
    return afp ? m_c[~m_sel] : m_c[m_sel];
  endfunction

  function automatic logic [7:0] exp_rd(logic rl, logic rh);
    if (rl) return m_c[~m_sel][7:0];
    if (rh) return m_c[~m_sel][15:8];
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic ce, logic jmp, logic afp, logic wl, logic wh,
                      logic rl, logic rh, logic [7:0] d, string tag);
    @(posedge clk); #1;
    cnt_en = ce; jump_en = jmp; addr_from_ptr = afp;
    wr_lo = wl; wr_hi = wh; rd_lo = rl; rd_hi = rh; wr_data = d;
    @(negedge clk);
    if (wl) m_c[~m_sel][7:0]  = d;
    if (wh) m_c[~m_sel][15:8] = d;
    if (ce) m_c[m_sel] = m_c[m_sel] + 16'd1;
    if (jmp) m_sel = ~m_sel;
    #1;
    chk({tag, " addr"}, 32'(addr), 32'(exp_addr(afp)));
    chk({tag, " rd_data"}, 32'(rd_data), 32'(exp_rd(rl, rh)));
    chk({tag, " rd_valid"}, 32'(rd_valid), 32'(rl | rh));
  endtask

  task automatic peek(logic afp, logic rl, logic rh, string tag);
    step(1'b0, 1'b0, afp, 1'b0, 1'b0, rl, rh, 8'h00, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20211;
    void'($urandom(seed));
    rst_n = 1'b0;
    cnt_en = 0; jump_en = 0; addr_from_ptr = 0;
    wr_lo = 0; wr_hi = 0; rd_lo = 0; rd_hi = 0; wr_data = 8'h00;
    m_c[0] = 16'h0000; m_c[1] = 16'h0000; m_sel = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state and counter 0 as IP
    peek(1'b0, 1'b0, 1'b0, "R1");
    peek(1'b1, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R1");
    peek(1'b1, 1'b0, 1'b1, "R1");
    // R2 / R3: increments move only IP
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R3");
    peek(1'b0, 1'b0, 1'b0, "R2");
    // R5 / R6: byte loads and reads of P
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h34, "R5");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h12, "R5");
    peek(1'b1, 1'b1, 1'b0, "R6");
    peek(1'b1, 1'b0, 1'b1, "R6");
    // R7: both read enables
    peek(1'b1, 1'b1, 1'b1, "R7");
    // R8: plain jump, return address in P
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
    peek(1'b0, 1'b0, 1'b0, "R8");
    // R9: increment and jump on one edge, load on the same edge
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R9");
    peek(1'b0, 1'b0, 1'b0, "R9");
    // R10: wrap of IP at 0xFFFF
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R10");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R10");
    // R11: no jump keeps roles
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R11");
    peek(1'b1, 1'b0, 1'b0, "R11");

    // random mix, R4 address selection throughout
    for (int i = 0; i < 3000; i++) begin
      logic [8:0] r;
      r = 9'($urandom);
      step(r[0], (r[1] & r[2]), r[3], r[4], r[5], r[6], r[7],
           8'($urandom), "R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule